// File: doc/BRIEF.md
# Signed/Unsigned Array Multiplier

This block multiplies two equal-width operands in a single combinational array and presents the full double-width product on a register one clock later. One mode input chooses whether both operands are plain unsigned binary or two's complement values. It travels with the operands and is captured in the same cycle as they are.

The array forms one AND-gated row per bit of operand b, with each row shifted left by its index, and adds the rows. Unsigned operands need nothing else. For signed operands the same array is reused. The terms that pair the sign bit of one operand with a non-sign bit of the other are inverted. Two constant ones are then added, one at bit WIDTH and one at the top bit of the product, and the sum wraps modulo 2^(2*WIDTH). Neither operand is ever sign-extended. A valid strobe goes with each operand pair. The product register loads only when that strobe is high.

Top module: `sgn_arr_mult`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and product_o is 0.
- R2: valid_o in any cycle equals valid_i sampled at the previous rising clock edge.
- R3: With signed_i = 0 and valid_i = 1, the next cycle's product_o is the unsigned product a_i*b_i in 16 bits. For example, 0xFF*0xFF gives 0xFE01.
- R4: With signed_i = 1 and valid_i = 1, the next cycle's product_o is the two's complement product of a_i and b_i in 16 bits. For example, 0x80*0x80 (that is -128*-128) gives 0x4000.
- R5: signed_i is sampled in the same edge as the operands. Alternating the mode on back-to-back valid pairs gives each product in its own mode: 0xFF*0xFF gives 0xFE01 unsigned and 0x0001 signed.
- R6: While valid_i is 0, product_o holds its last value whatever a_i, b_i and signed_i do.
- R7: Extreme signed operands give the correct result: -128*127 = 0xC080, 127*127 = 0x3F01 and -1*-128 = 0x0080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operand pair present this cycle |
| signed_i | input | 1 | 0 selects unsigned operands, 1 selects two's complement |
| a_i | input | WIDTH | Operand a |
| b_i | input | WIDTH | Operand b |
| valid_o | output | 1 | Product register holds a new result |
| product_o | output | 2*WIDTH | Registered product |

## Verification
Two things can fall in the same cycle. One is the capture of a new operand pair. The other is a mode change relative to the result currently on the output: when signed_i flips between back-to-back valid pairs, the array must switch its inversions and correction constants in the very cycle that the previous product is being presented. The bench provokes this with alternating modes on a fixed pair, and then with every operand pair streamed without gaps in each mode. Each cycle is judged against a behavioural model that uses the language's own unsigned and signed multiplication.

// File: rtl/sgn_mult_pkg.sv
package sgn_mult_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } mult_mode_e;
endpackage

// File: rtl/sgn_mult_pp_gen.sv
module sgn_mult_pp_gen #(
  parameter int WIDTH = 8
) (
  input  logic                        signed_i,
  input  logic [WIDTH-1:0]            a_i,
  input  logic [WIDTH-1:0]            b_i,
  output logic [WIDTH-1:0][WIDTH-1:0] rows_o
);
  localparam int TOP = WIDTH - 1;

  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    for (genvar c = 0; c < WIDTH; c++) begin : g_col
      // sign-by-nonsign terms are inverted in signed mode; sign-by-sign is not
      if ((r == TOP) != (c == TOP)) begin : g_inv
        assign rows_o[r][c] = (a_i[c] & b_i[r]) ^ signed_i;
      end else begin : g_plain
        assign rows_o[r][c] = a_i[c] & b_i[r];
      end
    end
  end
endmodule

// File: rtl/sgn_mult_row_sum.sv
module sgn_mult_row_sum #(
  parameter int WIDTH = 8
) (
  input  logic                        signed_i,
  input  logic [WIDTH-1:0][WIDTH-1:0] rows_i,
  output logic [2*WIDTH-1:0]          sum_o
);
  localparam int PW = 2 * WIDTH;
  localparam logic [PW-1:0] CORR = (PW'(1) << WIDTH) | (PW'(1) << (PW - 1));

  logic [WIDTH:0][PW-1:0] acc;

  assign acc[0] = signed_i ? CORR : '0;

  for (genvar r = 0; r < WIDTH; r++) begin : g_add
    logic [PW-1:0] shifted;
    assign shifted    = {{WIDTH{1'b0}}, rows_i[r]} << r;
    assign acc[r + 1] = acc[r] + shifted;
  end

  assign sum_o = acc[WIDTH];
endmodule

// File: rtl/sgn_arr_mult.sv
module sgn_arr_mult
  import sgn_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 signed_i,
  input  logic [WIDTH-1:0]     a_i,
  input  logic [WIDTH-1:0]     b_i,
  output logic                 valid_o,
  output logic [2*WIDTH-1:0]   product_o
);
  localparam int PW = 2 * WIDTH;

  mult_mode_e                 mode;
  logic [WIDTH-1:0][WIDTH-1:0] rows;
  logic [PW-1:0]               sum;
  logic                        valid_q;
  logic [PW-1:0]               prod_q;

  assign mode = mult_mode_e'(signed_i);

  sgn_mult_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .signed_i (mode == MODE_SIGNED),
    .a_i      (a_i),
    .b_i      (b_i),
    .rows_o   (rows)
  );

  sgn_mult_row_sum #(.WIDTH(WIDTH)) u_sum (
    .signed_i (mode == MODE_SIGNED),
    .rows_i   (rows),
    .sum_o    (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) prod_q <= sum;
    end
  end

  assign valid_o   = valid_q;
  assign product_o = prod_q;

  // array result against language multiply
  always_comb begin
    if (!$isunknown({a_i, b_i, signed_i})) begin
      if (mode == MODE_UNSIGNED)
        assert_unsigned_R3: assert (sum == PW'({{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i}));
      else
        assert_signed_R4: assert (sum == PW'($signed({{WIDTH{a_i[WIDTH-1]}}, a_i}) *
                                              $signed({{WIDTH{b_i[WIDTH-1]}}, b_i})));
    end
  end

  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (valid_o == $past(valid_i)));

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(valid_i)) |-> $stable(product_o));
endmodule

// File: tb/tb_sgn_arr_mult.sv
module tb_sgn_arr_mult;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_in = 1'b0;
  logic          mode_in = 1'b0;
  logic [W-1:0]  a_in = '0;
  logic [W-1:0]  b_in = '0;
  logic          valid_out;
  logic [PW-1:0] prod_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase_tag = "R1";

  logic          m_valid;
  logic [PW-1:0] m_prod;
  logic          m_mode;

  always #10 clk = ~clk;

  sgn_arr_mult #(.WIDTH(W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid_in),
    .signed_i  (mode_in),
    .a_i       (a_in),
    .b_i       (b_in),
    .valid_o   (valid_out),
    .product_o (prod_out)
  );

  function automatic logic [PW-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic s);
    int x, y;
    if (s) begin
      x = int'($signed(a));
      y = int'($signed(b));
    end else begin
      x = int'(a);
      y = int'(b);
    end
    return PW'(x * y);
  endfunction

  // behavioural reference, one register stage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_prod  <= '0;
      m_mode  <= 1'b0;
    end else begin
      m_valid <= valid_in;
      if (valid_in) begin
        m_prod <= ref_mul(a_in, b_in, mode_in);
        m_mode <= mode_in;
      end
    end
  end

  always @(negedge clk) begin
    string tag;
    cycles++;
    checks++;
    tag = (phase_tag != "") ? phase_tag : "R2";
    if (valid_out !== m_valid) begin
      errors++;
      $display("FAIL %s valid_o actual %0b expected %0b", tag, valid_out, m_valid);
    end
    checks++;
    if (phase_tag != "") tag = phase_tag;
    else if (!m_valid) tag = "R6";
    else tag = m_mode ? "R4" : "R3";
    if (prod_out !== m_prod) begin
      errors++;
      $display("FAIL %s product_o actual %h expected %h", tag, prod_out, m_prod);
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(logic v, logic s, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    #1;
    valid_in = v;
    mode_in  = s;
    a_in     = a;
    b_in     = b;
  endtask

  initial begin
    phase_tag = "R1";
    repeat (3) drive(1'b0, 1'b0, 8'h5A, 8'hA5);
    rst_n = 1'b1;
    phase_tag = "R7";
    drive(1'b1, 1'b1, 8'h80, 8'h80);
    drive(1'b1, 1'b1, 8'h80, 8'h7F);
    drive(1'b1, 1'b1, 8'h7F, 8'h7F);
    drive(1'b1, 1'b1, 8'hFF, 8'h80);
    drive(1'b1, 1'b0, 8'h80, 8'h80);
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    phase_tag = "R5";
    for (int k = 0; k < 8; k++) drive(1'b1, 1'(k % 2), 8'hFF, 8'hFF);
    phase_tag = "R6";
    for (int k = 0; k < 8; k++) drive(1'b0, 1'(k % 2), 8'(k * 37), 8'(k * 91 + 3));
    phase_tag = "";
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) drive(1'b1, 1'(s), W'(a), W'(b));
      end
      drive(1'b0, 1'b0, 8'h3C, 8'hC3);
      drive(1'b0, 1'b1, 8'hC3, 8'h3C);
    end
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    drive(1'b0, 1'b0, 8'h00, 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule